// File: doc/BRIEF.md
# DDS Serial Command Word Receiver

This block is the receiving end of a three-wire serial link that configures a direct digital synthesis waveform core. A host sends 16-bit command words, most significant bit first, over a serial clock, a data line and an active-low frame strobe. The receiver runs on the local system clock. It samples the three link wires through a short synchronizer chain and detects falling edges of the serial clock. It assembles words and decodes each complete word into an update of one of its registers.

The registers are a 14-bit control word, two 28-bit frequency tuning words and two 12-bit phase offsets. All of them drive the waveform core in parallel. A frequency word is written 14 bits at a time. It is either loaded whole from a low-then-high pair of writes, or changed one half at a time, with the control word choosing the half. A frame that ends before 16 bits have arrived leaves every register as it was.

Top module: `dds_cmd_rx`

## Requirements
- R1: While reset is asserted, and on its release, the control word, both frequency words and both phase words read zero.
- R2: The top two bits of a word select its target: 00 control, 01 frequency 0, 10 frequency 1, 11 phase. A control word loads bits 13:0 into the control output unchanged.
- R3: For a phase word, bit 13 picks phase register 0 (clear) or 1 (set), and bits 11:0 become its value. Bit 12 and the other phase register are left unchanged.
- R4: While control bit 13 (full-word mode) is set, the first frequency write holds bits 13:0 and leaves the register unchanged. A second write to the same register supplies bits 27:14, and both halves then load together.
- R5: While control bit 13 is clear, a frequency write changes one half only: bits 27:14 when control bit 12 is set, and bits 13:0 when it is clear.
- R6: The serial clock idles high, and data is taken on its falling edges while the frame strobe is low. A change of the data line while the serial clock is low has no effect on the word received.
- R7: A frame shorter than 16 bits changes no register. The bit count restarts whenever the frame strobe is high.
- R8: A held first half in full-word mode is dropped by any control write. A write to the other frequency register replaces it, and that write becomes the new first half.
- R9: Within one frame, every further 16 bits form a new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, idles high |
| ser_dat | input | 1 | Serial data, MSB first |
| frame_n | input | 1 | Active-low frame strobe |
| ctrl_word | output | 14 | Current control bits |
| freq0 | output | 28 | Frequency tuning word 0 |
| freq1 | output | 28 | Frequency tuning word 1 |
| phase0 | output | 12 | Phase offset 0 |
| phase1 | output | 12 | Phase offset 1 |

## Verification
A bit counter that has slipped shows up in the next word. The target register gets a rotated value, or an unrelated register is written, a few system cycles after the sixteenth falling edge. A stale pending half is different. It shows only when the later write completes a pair, so the sequences that drop a pending half are followed by two more writes before the frequency outputs are read. Each phase or half-word write is followed by a read of its neighbour register and the other half, which catches an error in the write enables on that same word.

// File: rtl/dds_cmd_pkg.sv
package dds_cmd_pkg;
    localparam int WORD_W  = 16;
    localparam int HALF_W  = 14;
    localparam int FREQ_W  = 2 * HALF_W;
    localparam int PHASE_W = 12;
    localparam int N_FREQ  = 2;
    localparam int N_PHASE = 2;
    localparam int BIT_FULL  = 13;  // full-word (paired) frequency mode
    localparam int BIT_UPPER = 12;  // half select when not paired
    localparam int BIT_PSEL  = 13;  // phase register select inside a phase word

    typedef enum logic [1:0] {
        TGT_CTRL  = 2'b00,
        TGT_FREQ0 = 2'b01,
        TGT_FREQ1 = 2'b10,
        TGT_PHASE = 2'b11
    } target_e;
endpackage

// File: rtl/dds_ser_shift.sv
module dds_ser_shift #(
    parameter int WORD_W = 16,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              frame_n,
    output logic              word_valid,
    output logic [WORD_W-1:0] word,
    output logic [$clog2(WORD_W)-1:0] bit_cnt,
    output logic              frame_idle
);
    localparam int CW = $clog2(WORD_W);
    localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

    typedef struct packed {
        logic [STAGES-1:0] sck;
        logic [STAGES-1:0] dat;
        logic [STAGES-1:0] fs;
        logic              sck_prev;
        logic [WORD_W-2:0] shreg;
        logic [CW-1:0]     cnt;
        logic              valid;
        logic [WORD_W-1:0] word;
    } state_t;

    state_t st_d, st_q;
    logic sck_now, fall;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.sck   = {st_q.sck[STAGES-2:0], ser_clk};
        st_d.dat   = {st_q.dat[STAGES-2:0], ser_dat};
        st_d.fs    = {st_q.fs[STAGES-2:0], frame_n};
        sck_now    = st_q.sck[STAGES-1];
        fall       = st_q.sck_prev & ~sck_now;
        st_d.sck_prev = sck_now;
        if (st_q.fs[STAGES-1]) begin
            st_d.cnt = '0;
        end else if (fall) begin
            st_d.shreg = {st_q.shreg[WORD_W-3:0], st_q.dat[STAGES-1]};
            if (st_q.cnt == LAST) begin
                st_d.valid = 1'b1;
                st_d.word  = {st_q.shreg, st_q.dat[STAGES-1]};
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.sck      <= '1;
            st_q.fs       <= '1;
            st_q.sck_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_valid = st_q.valid;
    assign word       = st_q.word;
    assign bit_cnt    = st_q.cnt;
    assign frame_idle = st_q.fs[STAGES-1];
endmodule

// File: rtl/dds_reg_bank.sv
module dds_reg_bank
    import dds_cmd_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            word_valid,
    input  logic [WORD_W-1:0]               word,
    output logic [HALF_W-1:0]               ctrl_word,
    output logic [N_FREQ-1:0][FREQ_W-1:0]   freq,
    output logic [N_PHASE-1:0][PHASE_W-1:0] phase,
    output logic                            pend
);
    typedef struct packed {
        logic [HALF_W-1:0]               ctrl;
        logic [N_FREQ-1:0][FREQ_W-1:0]   freq;
        logic [N_PHASE-1:0][PHASE_W-1:0] ph;
        logic                            pend;
        logic                            pend_idx;
        logic [HALF_W-1:0]               pend_lo;
    } bank_t;

    bank_t bk_d, bk_q;
    target_e          tgt;
    logic [HALF_W-1:0] payload;
    logic             fidx;

    always_comb begin
        bk_d    = bk_q;
        tgt     = target_e'(word[WORD_W-1 -: 2]);
        payload = word[HALF_W-1:0];
        fidx    = (tgt == TGT_FREQ1);
        if (word_valid) begin
            unique case (tgt)
                TGT_CTRL: begin
                    bk_d.ctrl = payload;
                    bk_d.pend = 1'b0;
                end
                TGT_FREQ0, TGT_FREQ1: begin
                    if (bk_q.ctrl[BIT_FULL]) begin
                        if (bk_q.pend && (bk_q.pend_idx == fidx)) begin
                            bk_d.freq[fidx] = {payload, bk_q.pend_lo};
                            bk_d.pend       = 1'b0;
                        end else begin
                            bk_d.pend     = 1'b1;
                            bk_d.pend_idx = fidx;
                            bk_d.pend_lo  = payload;
                        end
                    end else begin
                        bk_d.pend = 1'b0;
                        if (bk_q.ctrl[BIT_UPPER])
                            bk_d.freq[fidx][FREQ_W-1:HALF_W] = payload;
                        else
                            bk_d.freq[fidx][HALF_W-1:0] = payload;
                    end
                end
                TGT_PHASE: begin
                    bk_d.ph[word[BIT_PSEL]] = word[PHASE_W-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign ctrl_word = bk_q.ctrl;
    assign freq      = bk_q.freq;
    assign phase     = bk_q.ph;
    assign pend      = bk_q.pend;
endmodule

// File: rtl/dds_cmd_rx.sv
module dds_cmd_rx
    import dds_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_clk,
    input  logic               ser_dat,
    input  logic               frame_n,
    output logic [HALF_W-1:0]  ctrl_word,
    output logic [FREQ_W-1:0]  freq0,
    output logic [FREQ_W-1:0]  freq1,
    output logic [PHASE_W-1:0] phase0,
    output logic [PHASE_W-1:0] phase1
);
    logic                            word_valid;
    logic [WORD_W-1:0]               word;
    logic [$clog2(WORD_W)-1:0]       bit_cnt;
    logic                            frame_idle;
    logic [N_FREQ-1:0][FREQ_W-1:0]   freq;
    logic [N_PHASE-1:0][PHASE_W-1:0] phase;
    logic                            pend;

    dds_ser_shift #(.WORD_W(WORD_W), .STAGES(SYNC_STAGES)) shift_i (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .frame_n(frame_n), .word_valid(word_valid), .word(word),
        .bit_cnt(bit_cnt), .frame_idle(frame_idle)
    );

    dds_reg_bank bank_i (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word(word),
        .ctrl_word(ctrl_word), .freq(freq), .phase(phase), .pend(pend)
    );

    assign freq0  = freq[0];
    assign freq1  = freq[1];
    assign phase0 = phase[0];
    assign phase1 = phase[1];
endmodule

// File: rtl/dds_cmd_rx_chk.sv
module dds_cmd_rx_chk
    import dds_cmd_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               word_valid,
    input logic [WORD_W-1:0]  word,
    input logic [$clog2(WORD_W)-1:0] bit_cnt,
    input logic               frame_idle,
    input logic               pend,
    input logic [HALF_W-1:0]  ctrl_word,
    input logic [FREQ_W-1:0]  freq0,
    input logic [FREQ_W-1:0]  freq1,
    input logic [PHASE_W-1:0] phase0,
    input logic [PHASE_W-1:0] phase1
);
    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (ctrl_word == '0 && freq0 == '0 && freq1 == '0 && phase0 == '0 && phase1 == '0)); // R1
    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (word_valid && word[15:14] == 2'b00) |=> (ctrl_word == $past(word[13:0]))); // R2
    AST_PHASE_NO_FREQ: assert property (@(posedge clk) disable iff (!rst_n) (word_valid && word[15:14] == 2'b11) |=> ($stable(freq0) && $stable(freq1))); // R3
    AST_FIRST_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (word_valid && word[15:14] == 2'b01 && ctrl_word[BIT_FULL] && !pend) |=> ($stable(freq0) && pend)); // R4
    AST_UPPER_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (word_valid && word[15:14] == 2'b01 && !ctrl_word[BIT_FULL] && ctrl_word[BIT_UPPER]) |=> (freq0[13:0] == $past(freq0[13:0]))); // R5
    AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) frame_idle |=> (bit_cnt == '0)); // R7
    AST_NO_WORD_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n) !word_valid |=> ($stable(freq0) && $stable(freq1) && $stable(phase0) && $stable(phase1) && $stable(ctrl_word))); // R7
    AST_CTRL_DROPS_PEND: assert property (@(posedge clk) disable iff (!rst_n) (word_valid && word[15:14] == 2'b00) |=> !pend); // R8
    AST_WORD_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n) word_valid |-> (bit_cnt == '0)); // R9
endmodule

bind dds_cmd_rx dds_cmd_rx_chk chk_i (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word(word),
    .bit_cnt(bit_cnt), .frame_idle(frame_idle), .pend(pend),
    .ctrl_word(ctrl_word), .freq0(freq0), .freq1(freq1),
    .phase0(phase0), .phase1(phase1)
);

// File: tb/dds_cmd_rx_tb.sv
module dds_cmd_rx_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b1;
    logic        ser_dat = 1'b0;
    logic        frame_n = 1'b1;
    logic [13:0] ctrl_word;
    logic [27:0] freq0, freq1;
    logic [11:0] phase0, phase1;
    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;  // 250 MHz

    dds_cmd_rx dut_i (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .frame_n(frame_n), .ctrl_word(ctrl_word), .freq0(freq0),
        .freq1(freq1), .phase0(phase0), .phase1(phase1)
    );

    typedef struct packed {
        logic [15:0] w;
        logic [2:0]  sel;   // 0 ctrl, 1 freq0, 2 freq1, 3 phase0, 4 phase1
        logic [3:0]  rq;
        logic [27:0] exp;
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{16'h2000, 3'd0, 4'd2, 28'h0002000},  // R2 full-word mode on
        '{16'h5234, 3'd1, 4'd4, 28'h0000000},  // R4 first half held
        '{16'h4ABC, 3'd1, 4'd4, 28'h2AF1234},  // R4 pair completes
        '{16'hBFFF, 3'd2, 4'd4, 28'h0000000},
        '{16'h8001, 3'd2, 4'd4, 28'h0007FFF},
        '{16'h1000, 3'd0, 4'd2, 28'h0001000},  // R5 upper half mode
        '{16'h4155, 3'd1, 4'd5, 28'h0555234},
        '{16'h0000, 3'd0, 4'd2, 28'h0000000},  // R5 lower half mode
        '{16'hA222, 3'd2, 4'd5, 28'h0006222},
        '{16'hCABC, 3'd3, 4'd3, 28'h0000ABC},  // R3
        '{16'hE123, 3'd4, 4'd3, 28'h0000123},
        '{16'hF456, 3'd4, 4'd3, 28'h0000456}   // R3 bit 12 ignored
    };

    function automatic logic [27:0] get_out(input logic [2:0] sel);
        case (sel)
            3'd0: return {14'd0, ctrl_word};
            3'd1: return freq0;
            3'd2: return freq1;
            3'd3: return {16'd0, phase0};
            default: return {16'd0, phase1};
        endcase
    endfunction

    task automatic check(input string req, input logic [27:0] act, input logic [27:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // send nbits of w MSB first; flip data while clock low when disturb is set
    task automatic send_bits(input logic [15:0] w, input int nbits, input bit disturb);
        for (int i = 15; i > 15 - nbits; i--) begin
            ser_dat = w[i];
            tick(4);
            ser_clk = 1'b0;
            tick(2);
            if (disturb) ser_dat = ~w[i];
            tick(2);
            ser_clk = 1'b1;
        end
    endtask

    task automatic frame(input logic [15:0] w);
        frame_n = 1'b0;
        tick(4);
        send_bits(w, 16, 1'b0);
        tick(4);
        frame_n = 1'b1;
        tick(10);
    endtask

    initial begin
        tick(3);
        check("R1 ctrl", {14'd0, ctrl_word}, 28'd0);
        check("R1 freq0", freq0, 28'd0);
        check("R1 phase1", {16'd0, phase1}, 28'd0);
        rst_n = 1'b1;
        tick(4);
        check("R1 freq1 after release", freq1, 28'd0);

        for (int i = 0; i < 12; i++) begin
            frame(VEC[i].w);
            n_chk++;
            if (get_out(VEC[i].sel) !== VEC[i].exp) begin
                n_fail++;
                $display("FAIL R%0d vector %0d actual=%h expected=%h", VEC[i].rq, i,
                         get_out(VEC[i].sel), VEC[i].exp);
            end
        end
        check("R3 phase0 untouched", {16'd0, phase0}, 28'h0000ABC);
        check("R5 freq0 lower kept", freq0, 28'h0555234);

        // R7: short frame, then a full word in a fresh frame
        frame_n = 1'b0;
        tick(4);
        send_bits(16'h5FFF, 10, 1'b0);
        tick(4);
        frame_n = 1'b1;
        tick(10);
        check("R7 short frame ignored", freq0, 28'h0555234);
        check("R7 short frame ctrl", {14'd0, ctrl_word}, 28'd0);
        frame(16'h0ABC);
        check("R7 count restart", {14'd0, ctrl_word}, 28'h0000ABC);

        // R6: data toggled while clock low is not sampled
        frame_n = 1'b0;
        tick(4);
        send_bits(16'h0003, 16, 1'b1);
        tick(4);
        frame_n = 1'b1;
        tick(10);
        check("R6 falling edge sample", {14'd0, ctrl_word}, 28'h0000003);

        // R9: two words in one frame
        frame_n = 1'b0;
        tick(4);
        send_bits(16'hC111, 16, 1'b0);
        send_bits(16'hE222, 16, 1'b0);
        tick(4);
        frame_n = 1'b1;
        tick(10);
        check("R9 first word", {16'd0, phase0}, 28'h0000111);
        check("R9 second word", {16'd0, phase1}, 28'h0000222);

        // R8: control write drops pending half
        frame(16'h2000);
        frame(16'h4001);
        frame(16'h2000);
        frame(16'h4002);
        check("R8 after ctrl drop", freq0, 28'h0555234);
        frame(16'h4003);
        check("R8 new pair", freq0, 28'h000C002);
        // R8: other register write replaces pending half
        frame(16'h4005);
        frame(16'h8007);
        frame(16'h4009);
        check("R8 other reg freq0", freq0, 28'h000C002);
        check("R8 other reg freq1", freq1, 28'h0006222);
        frame(16'h400A);
        check("R8 replaced pair", freq0, 28'h0028009);

        // R1: reset in mid run
        rst_n = 1'b0;
        tick(2);
        check("R1 mid reset freq0", freq0, 28'd0);
        check("R1 mid reset phase0", {16'd0, phase0}, 28'd0);
        check("R1 mid reset ctrl", {14'd0, ctrl_word}, 28'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R1-run hung actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule